// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds the general-purpose integer registers of a 32-bit core in a form where the same storage can be reached as a full 32-bit word, as its low 16-bit half, or as individual bytes. There are eight general registers, two combinational read ports and one synchronous write port. Each port names a register by index and chooses the width of the access with a 2-bit size code. A narrow write merges its slice into the stored word and leaves every other bit alone. A narrow read returns its slice zero-extended and placed at bit 0.

The high byte (bits 15:8) can be reached as a separate byte only on registers 0 to 3. A high-byte write to registers 4 to 7 is dropped and raises an error pulse. Six 16-bit segment registers sit in their own small bank with one read port and one write port. A 32-bit instruction pointer can be written in full or in its low half, and it is presented both in full and as its low 16 bits.

Register index order is 0 accumulator, 1 counter, 2 data, 3 base, 4 stack pointer, 5 base pointer, 6 source index, 7 destination index. Size codes are 00 dword, 01 word (bits 15:0), 10 low byte (bits 7:0), 11 high byte (bits 15:8). A narrow write always takes its data from the low bits of `wr_data`. For both byte sizes this means `wr_data[7:0]`.

Top module: `gprf_top`

## Requirements
- R1: While `rst` is high at a clock edge, all general registers, segment registers and the instruction pointer become zero, and `wr_err` becomes low.
- R2: A write with size 00 replaces all 32 bits of the selected register with `wr_data`.
- R3: A write with size 01 replaces bits 15:0 with `wr_data[15:0]` and leaves bits 31:16 unchanged.
- R4: A write with size 10 replaces bits 7:0 with `wr_data[7:0]`. A write with size 11 to registers 0–3 replaces bits 15:8 with `wr_data[7:0]`. In both cases all other bits stay unchanged.
- R5: A read returns the selected view zero-extended from bit 0: size 00 returns the whole register, 01 returns bits 15:0, 10 returns bits 7:0, and 11 returns bits 15:8 in result bits 7:0.
- R6: A size-11 write to registers 4–7 changes no register, and `wr_err` is high for exactly the one cycle after that clock edge. A size-11 read of registers 4–7 returns zero.
- R7: The two read ports are combinational and independent, and each port may use any index and size in the same cycle.
- R8: When a read and a write address the same register in one cycle, the read returns the value from before the write until the clock edge. After the edge it returns the merged value.
- R9: Segment registers 0–5 are 16 bits wide. A segment write to index 6 or 7 has no effect, and a segment read of index 6 or 7 returns zero.
- R10: The instruction pointer takes all 32 bits of `ip_wr_data` when `ip_wr_word` is low, or only bits 15:0 when it is high (keeping bits 31:16). `ip_low` always equals bits 15:0 of `ip_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 32 | Read port A result, zero-extended |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B result, zero-extended |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data; narrow slices taken from the low bits |
| wr_err | output | 1 | One-cycle pulse after a rejected high-byte write |
| seg_rd_idx | input | 3 | Segment read index |
| seg_rd_data | output | 16 | Segment read data |
| seg_wr_en | input | 1 | Segment write enable |
| seg_wr_idx | input | 3 | Segment write index |
| seg_wr_data | input | 16 | Segment write data |
| ip_wr_en | input | 1 | Instruction pointer write enable |
| ip_wr_word | input | 1 | High: write only bits 15:0 |
| ip_wr_data | input | 32 | Instruction pointer write data |
| ip_full | output | 32 | Instruction pointer, 32 bits |
| ip_low | output | 16 | Instruction pointer, low 16 bits |

## Verification
A wrong merge corrupts bits outside the written slice. That damage is invisible to a read of the same width, so after every write the bench reads every register in every view on both ports. A stale or misplaced bit therefore shows up at a port half a cycle after the edge that caused it. Rejected high-byte writes are checked through the full-width view of the target register and through `wr_err` in the cycle after the edge. Same-cycle read/write overlap is sampled on both sides of the edge, so a forwarding path would be caught before the edge.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    localparam int GPR_W          = 32;
    localparam int GPR_COUNT      = 8;
    localparam int BYTE_PAIR_REGS = 4;
    localparam int SEG_W          = 16;
    localparam int SEG_COUNT      = 6;

    typedef enum logic [1:0] {
        SZ_DWORD = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_LOW   = 2'b10,
        SZ_HIGH  = 2'b11
    } acc_size_e;

    typedef logic [GPR_W-1:0] gpr_word_t;

    // Registers below BYTE_PAIR_REGS expose bits 15:8 as a byte
    function automatic logic high_ok(input logic [31:0] idx);
        return idx < BYTE_PAIR_REGS;
    endfunction

    // Fold a write slice into a stored word
    function automatic gpr_word_t merge_slice(input gpr_word_t old_v,
                                              input gpr_word_t new_v,
                                              input acc_size_e sz);
        gpr_word_t r;
        r = old_v;
        unique case (sz)
            SZ_DWORD: r = new_v;
            SZ_WORD:  r[15:0] = new_v[15:0];
            SZ_LOW:   r[7:0] = new_v[7:0];
            SZ_HIGH:  r[15:8] = new_v[7:0];
        endcase
        return r;
    endfunction

    // Extract a slice and zero-extend it from bit 0
    function automatic gpr_word_t view_slice(input gpr_word_t v, input acc_size_e sz);
        gpr_word_t r;
        r = '0;
        unique case (sz)
            SZ_DWORD: r = v;
            SZ_WORD:  r[15:0] = v[15:0];
            SZ_LOW:   r[7:0] = v[7:0];
            SZ_HIGH:  r[7:0] = v[15:8];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gprf_cell.sv
module gprf_cell
    import gprf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  acc_size_e size,
    input  gpr_word_t wdata,
    output gpr_word_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= merge_slice(q, wdata, size);
        end
    end

    // R2: a full-width write lands verbatim
    a_r2_dword_store: assert property (@(posedge clk) disable iff (rst)
        (we && size == SZ_DWORD) |=> (q == $past(wdata)));

    // R4: byte writes keep bits 31:16
    a_r4_byte_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (we && (size == SZ_LOW || size == SZ_HIGH)) |=> (q[31:16] == $past(q[31:16])));

endmodule

// File: rtl/gprf_read_view.sv
module gprf_read_view
    import gprf_pkg::*;
#(
    parameter int NUM_REGS = GPR_COUNT,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  gpr_word_t          regs [NUM_REGS],
    input  logic [IDX_W-1:0]   idx,
    input  acc_size_e          size,
    output gpr_word_t          data
);

    gpr_word_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) sel = regs[i];
        end
    end

    always_comb begin
        if (size == SZ_HIGH && !high_ok(32'(idx))) data = '0;
        else data = view_slice(sel, size);
    end

    // R6: high-byte reads of registers without a byte pair are zero
    always_comb begin
        if (size == SZ_HIGH && !high_ok(32'(idx)))
            a_r6_high_read_zero: assert (data == '0);
    end

endmodule

// File: rtl/gprf_seg_bank.sv
module gprf_seg_bank
    import gprf_pkg::*;
#(
    parameter int NUM_SEG  = SEG_COUNT,
    parameter int WIDTH    = SEG_W,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] seg_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) seg_q[g] <= '0;
            else if (we && widx == IDX_W'(g)) seg_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (ridx == IDX_W'(i)) rdata = seg_q[i];
        end
    end

    // R9: indices past the bank read as zero
    a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
        (32'(ridx) >= NUM_SEG) |-> (rdata == '0));

    // R9: an in-range write is visible the next cycle at that index
    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && 32'(widx) < NUM_SEG && ridx == widx) |=>
        (($past(ridx) != ridx) || rdata == $past(wdata) || ($past(we) && we && widx == ridx)));

endmodule

// File: rtl/gprf_ip.sv
module gprf_ip
    import gprf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  logic      word_only,
    input  gpr_word_t wdata,
    output gpr_word_t ip_q
);

    always_ff @(posedge clk) begin
        if (rst) ip_q <= '0;
        else if (we) ip_q <= word_only ? {ip_q[31:16], wdata[15:0]} : wdata;
    end

    // R10: a half write keeps the upper half
    a_r10_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (we && word_only) |=> (ip_q[31:16] == $past(ip_q[31:16]) && ip_q[15:0] == $past(wdata[15:0])));

endmodule

// File: rtl/gprf_top.sv
module gprf_top
    import gprf_pkg::*;
#(
    parameter int NUM_GPR  = GPR_COUNT,
    parameter int NUM_SEG  = SEG_COUNT,
    localparam int IDX_W   = $clog2(NUM_GPR),
    localparam int SIDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [1:0]        rd_a_size,
    output logic [GPR_W-1:0]  rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [1:0]        rd_b_size,
    output logic [GPR_W-1:0]  rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_size,
    input  logic [GPR_W-1:0]  wr_data,
    output logic              wr_err,
    input  logic [SIDX_W-1:0] seg_rd_idx,
    output logic [SEG_W-1:0]  seg_rd_data,
    input  logic              seg_wr_en,
    input  logic [SIDX_W-1:0] seg_wr_idx,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              ip_wr_en,
    input  logic              ip_wr_word,
    input  logic [GPR_W-1:0]  ip_wr_data,
    output logic [GPR_W-1:0]  ip_full,
    output logic [15:0]       ip_low
);

    localparam int NUM_RD = 2;

    acc_size_e wsize;
    logic      illegal_wr;
    gpr_word_t gpr_q [NUM_GPR];

    assign wsize      = acc_size_e'(wr_size);
    assign illegal_wr = wr_en && wsize == SZ_HIGH && !high_ok(32'(wr_idx));

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        gprf_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && !illegal_wr && wr_idx == IDX_W'(g)),
            .size  (wsize),
            .wdata (wr_data),
            .q     (gpr_q[g])
        );
    end

    logic [IDX_W-1:0] rp_idx  [NUM_RD];
    acc_size_e        rp_size [NUM_RD];
    gpr_word_t        rp_data [NUM_RD];

    assign rp_idx[0]  = rd_a_idx;
    assign rp_idx[1]  = rd_b_idx;
    assign rp_size[0] = acc_size_e'(rd_a_size);
    assign rp_size[1] = acc_size_e'(rd_b_size);
    assign rd_a_data  = rp_data[0];
    assign rd_b_data  = rp_data[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gprf_read_view #(.NUM_REGS(NUM_GPR)) u_view (
            .regs (gpr_q),
            .idx  (rp_idx[p]),
            .size (rp_size[p]),
            .data (rp_data[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= illegal_wr;
    end

    gprf_seg_bank #(.NUM_SEG(NUM_SEG), .WIDTH(SEG_W), .IDX_W(SIDX_W)) u_seg (
        .clk   (clk),
        .rst   (rst),
        .we    (seg_wr_en),
        .widx  (seg_wr_idx),
        .wdata (seg_wr_data),
        .ridx  (seg_rd_idx),
        .rdata (seg_rd_data)
    );

    gprf_ip u_ip (
        .clk       (clk),
        .rst       (rst),
        .we        (ip_wr_en),
        .word_only (ip_wr_word),
        .wdata     (ip_wr_data),
        .ip_q      (ip_full)
    );

    assign ip_low = ip_full[15:0];

    // R1: reset leaves the pointer cleared and no error pending
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ip_full == '0 && !wr_err && gpr_q[0] == '0));

    // R6: a rejected write pulses the error flag
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsize == SZ_HIGH && 32'(wr_idx) >= BYTE_PAIR_REGS) |=> wr_err);

    // R6: a rejected write leaves its target intact
    a_r6_target_intact: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsize == SZ_HIGH && 32'(wr_idx) >= BYTE_PAIR_REGS) |=>
        (gpr_q[$past(wr_idx)] == $past(gpr_q[wr_idx])));

    // R3: a word write keeps bits 31:16
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsize == SZ_WORD) |=>
        (gpr_q[$past(wr_idx)][31:16] == $past(gpr_q[wr_idx][31:16])));

    // R8: the read before an edge shows the pre-write value
    a_r8_read_old: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_a_idx == wr_idx && rp_size[0] == SZ_DWORD) |-> (rd_a_data == gpr_q[wr_idx]));

endmodule

// File: tb/tb_gprf_top.sv
`timescale 1ns/1ps
module tb_gprf_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd_a_idx, rd_b_idx, wr_idx, seg_rd_idx, seg_wr_idx;
    logic [1:0]  rd_a_size, rd_b_size, wr_size;
    logic [31:0] rd_a_data, rd_b_data, wr_data, ip_wr_data, ip_full;
    logic        wr_en, wr_err, seg_wr_en, ip_wr_en, ip_wr_word;
    logic [15:0] seg_rd_data, seg_wr_data, ip_low;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_gpr [8];
    logic [15:0] m_seg [8];
    logic [31:0] m_ip;

    always #5 clk = ~clk;

    gprf_top dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .seg_rd_idx(seg_rd_idx), .seg_rd_data(seg_rd_data),
        .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_data(seg_wr_data),
        .ip_wr_en(ip_wr_en), .ip_wr_word(ip_wr_word), .ip_wr_data(ip_wr_data),
        .ip_full(ip_full), .ip_low(ip_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_view(input int idx, input int sz, input logic [31:0] v);
        case (sz)
            0: return v;
            1: return v % 32'h10000;
            2: return v % 32'h100;
            default: return (idx < 4) ? (v / 32'h100) % 32'h100 : 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_merge(input int sz, input logic [31:0] o, input logic [31:0] d);
        case (sz)
            0: return d;
            1: return (o & 32'hFFFF0000) | (d & 32'h0000FFFF);
            2: return (o & 32'hFFFFFF00) | (d & 32'h000000FF);
            default: return (o & 32'hFFFF00FF) | ((d & 32'hFF) << 8);
        endcase
    endfunction

    // R5 R7: every view of every register on both ports
    task automatic sweep_reads(input string req);
        for (int r = 0; r < 8; r++) begin
            for (int s = 0; s < 4; s++) begin
                rd_a_idx = 3'(r); rd_a_size = 2'(s);
                rd_b_idx = 3'(7 - r); rd_b_size = 2'(3 - s);
                #0.1;
                chk(req, rd_a_data, exp_view(r, s, m_gpr[r]));
                chk(req, rd_b_data, exp_view(7 - r, 3 - s, m_gpr[7 - r]));
            end
        end
    endtask

    task automatic gpr_write(input int idx, input int sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_size = 2'(sz); wr_data = d;
        @(posedge clk); #1;
        if (!(sz == 3 && idx >= 4)) m_gpr[idx] = exp_merge(sz, m_gpr[idx], d);
        chk("R6 err flag", {31'b0, wr_err}, {31'b0, (sz == 3 && idx >= 4)});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_idx = 0; wr_size = 0; wr_data = 0;
        rd_a_idx = 0; rd_a_size = 0; rd_b_idx = 0; rd_b_size = 0;
        seg_rd_idx = 0; seg_wr_en = 0; seg_wr_idx = 0; seg_wr_data = 0;
        ip_wr_en = 0; ip_wr_word = 0; ip_wr_data = 0;
        for (int i = 0; i < 8; i++) begin m_gpr[i] = 0; m_seg[i] = 0; end
        m_ip = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: cleared state
        sweep_reads("R1 reset gpr");
        for (int i = 0; i < 8; i++) begin
            seg_rd_idx = 3'(i); #0.1;
            chk("R1 reset seg", {16'b0, seg_rd_data}, 32'h0);
        end
        chk("R1 reset ip", ip_full, 32'h0);
        chk("R1 reset err", {31'b0, wr_err}, 32'h0);

        // R2 R3 R4 R6: every register at every size, full sweep after each
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 8; r++) begin
                gpr_write(r, s, 32'hC3A55A3C ^ (32'(r) * 32'h11111111) ^ (32'(s) << 12) ^ (32'(s) * 32'h0B0B0000));
                sweep_reads(s == 0 ? "R2 dword write" : s == 1 ? "R3 word write" :
                            s == 2 ? "R4 low byte write" : "R4 R6 high byte write");
            end
        end
        @(posedge clk); #1;
        chk("R6 err one cycle", {31'b0, wr_err}, 32'h0);

        // R6: rejected write followed by idle drops the flag after one cycle
        gpr_write(6, 3, 32'h000000EE);
        @(posedge clk); #1;
        chk("R6 err drops", {31'b0, wr_err}, 32'h0);
        rd_a_idx = 3'd6; rd_a_size = 2'd0; #0.1;
        chk("R6 target intact", rd_a_data, m_gpr[6]);

        // R8: same-register read and write in one cycle
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            wr_en = 1; wr_idx = 3'd2; wr_size = 2'(s); wr_data = 32'h5EED0000 + 32'(s) * 32'h01230123;
            rd_a_idx = 3'd2; rd_a_size = 2'd0; rd_b_idx = 3'd2; rd_b_size = 2'(s);
            #1;
            chk("R8 old dword", rd_a_data, m_gpr[2]);
            chk("R8 old slice", rd_b_data, exp_view(2, s, m_gpr[2]));
            @(posedge clk); #1;
            m_gpr[2] = exp_merge(s, m_gpr[2], wr_data);
            chk("R8 new dword", rd_a_data, m_gpr[2]);
            chk("R8 new slice", rd_b_data, exp_view(2, s, m_gpr[2]));
            @(negedge clk); wr_en = 0;
        end

        // R9: segment bank including out-of-range indices
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            seg_wr_en = 1; seg_wr_idx = 3'(i); seg_wr_data = 16'h1000 + 16'(i) * 16'h0111;
            @(posedge clk); #1;
            if (i < 6) m_seg[i] = seg_wr_data;
            @(negedge clk); seg_wr_en = 0;
        end
        for (int i = 0; i < 8; i++) begin
            seg_rd_idx = 3'(i); #0.1;
            chk("R9 segment read", {16'b0, seg_rd_data}, {16'b0, m_seg[i]});
        end

        // R10: instruction pointer full and half writes
        @(negedge clk); ip_wr_en = 1; ip_wr_word = 0; ip_wr_data = 32'hDEADBEEF;
        @(posedge clk); #1; m_ip = 32'hDEADBEEF;
        chk("R10 ip full", ip_full, m_ip);
        chk("R10 ip low", {16'b0, ip_low}, m_ip & 32'hFFFF);
        @(negedge clk); ip_wr_word = 1; ip_wr_data = 32'h12345678;
        @(posedge clk); #1; m_ip = 32'hDEAD5678;
        chk("R10 ip half", ip_full, m_ip);
        chk("R10 ip low half", {16'b0, ip_low}, 32'h5678);
        @(negedge clk); ip_wr_en = 0;

        // R1: reset again after activity
        rst = 1;
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) m_gpr[i] = 0;
        @(negedge clk); rst = 0;
        sweep_reads("R1 re-reset gpr");
        chk("R1 re-reset ip", ip_full, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule